// File: doc/BRIEF.md
# Interleaved Page-Mode DRAM Row Controller

This block sits between a CPU bus that addresses 16-bit words and a group of up to four page-mode DRAM banks. Every accepted address is split into a bank, a row and a column according to a programmable size-and-interleave mode. The bank-select bits lie directly above the column field, so consecutive pages fall into alternating banks of a pair (or rotate across four banks). Address bits above the row field belong to an outside high-level decoder and are not used here.

The controller keeps one row open in each bank. An access to the open row of its bank costs a single column command. Any other access first closes the old row, then opens the new one, then issues the column command. A refresh request closes every open row before it is acknowledged. An optional watchdog closes any row that has been held open for a programmed number of clock cycles. The block emits abstract commands (activate, column, precharge) together with the bank and the multiplexed row or column address. It does not model DRAM electrical timing.

Top module: `dram_page_ctl`

## Requirements
- R1: `cfg_mode` selects the split of the byte address `A`. Modes 0/1/2 use column A[9:1]; modes 3/4/5 use A[10:1]; modes 6/7 use A[11:1]. Modes 0/3/6 have no bank bits. Modes 1/4/7 take one bank bit and modes 2/5 take two, starting just above the column. The row has the same width as the column and begins just above the bank bits.
- R2: Address bit 0 and every bit above the row field have no effect on bank, row, column or hit decision.
- R3: An access to a bank whose open row equals the decoded row produces exactly one COL command and nothing else.
- R4: An access to an open bank with a different row produces PRE, ACT, COL to that bank on three consecutive cycles, starting the cycle after acceptance.
- R5: An access to a closed bank produces ACT then COL on consecutive cycles.
- R6: `cmd_op` encodes 0 = none, 1 = ACT, 2 = COL, 3 = PRE. `cmd_addr` carries the row during ACT and the column during COL.
- R7: While `ref_req` is high, `req_ready` is low. Each open bank receives one PRE, in ascending bank order. Then `ref_ack` is high for exactly one cycle, with no bank open.
- R8: After a refresh, every bank is closed, so the next access to any bank starts with ACT.
- R9: With `cfg_tmo_en` high, a bank left idle after its ACT receives a PRE exactly `TMO_CYCLES`+2 cycles after that ACT. No row stays open more than `TMO_CYCLES`+8 cycles, and an access already started is never cut short.
- R10: With `cfg_tmo_en` low, an idle open row stays open indefinitely, and a later access to it is a hit.
- R11: After reset, `req_ready` is high, `cmd_op` is 0, `ref_ack` is low and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Size and interleave mode (R1) |
| cfg_tmo_en | input | 1 | Enables the row-open watchdog |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge when both are high |
| req_addr | input | 24 | Byte address of the access |
| ref_req | input | 1 | Refresh request, held until acknowledged |
| ref_ack | output | 1 | One-cycle refresh acknowledge |
| cmd_op | output | 2 | Command code (R6) |
| cmd_bank | output | 2 | Bank the command targets |
| cmd_addr | output | 11 | Row (ACT) or column (COL) address |

## Verification
The properties assume the following input behaviour. `cfg_mode` and `cfg_tmo_en` change only when every bank is closed. `ref_req` falls in the cycle after `ref_ack`. `req_valid` is never raised together with a pending refresh. The stimulus follows these rules directly: it reconfigures only right after a refresh has completed, it drops the refresh request at the acknowledge, and it presents each access only after the expected commands of the previous access have drained. The watchdog checks run with a short cycle limit, so that the exact precharge cycle and the open-time bound can both be observed.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    localparam int ADDR_W = 24;
    localparam int CA_W   = 11;
    localparam int BANK_N = 4;
    localparam int BK_W   = $clog2(BANK_N);
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_COL = 2'd2,
        OP_PRE = 2'd3
    } op_e;

    typedef struct packed {
        logic [BK_W-1:0] bank;
        logic [CA_W-1:0] row;
        logic [CA_W-1:0] col;
    } dec_t;

    // column (and row) width per mode
    function automatic int col_bits(input logic [MODE_W-1:0] m);
        int w;
        if (m < 3'd3)      w = 9;
        else if (m < 3'd6) w = 10;
        else               w = 11;
        return w;
    endfunction

    // number of bank-select bits per mode
    function automatic int bank_bits(input logic [MODE_W-1:0] m);
        int b;
        case (m)
            3'd1, 3'd4, 3'd7: b = 1;
            3'd2, 3'd5:       b = 2;
            default:          b = 0;
        endcase
        return b;
    endfunction

    function automatic dec_t split_addr(input logic [ADDR_W-1:0] a,
                                        input logic [MODE_W-1:0] m);
        dec_t d;
        logic [ADDR_W-1:0] w;
        logic [ADDR_W-1:0] cmask;
        logic [ADDR_W-1:0] bmask;
        int cw;
        int bb;
        cw    = col_bits(m);
        bb    = bank_bits(m);
        cmask = ~({ADDR_W{1'b1}} << cw);
        bmask = ~({ADDR_W{1'b1}} << bb);
        w      = a >> 1;
        d.col  = CA_W'(w & cmask);
        w      = w >> cw;
        d.bank = BK_W'(w & bmask);
        w      = w >> bb;
        d.row  = CA_W'(w & cmask);
        return d;
    endfunction

    function automatic logic [BK_W-1:0] lowest_set(input logic [BANK_N-1:0] v);
        logic [BK_W-1:0] r;
        r = '0;
        for (int i = BANK_N - 1; i >= 0; i--) begin
            if (v[i]) r = BK_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dpg_addr_dec.sv
module dpg_addr_dec
    import dpg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [MODE_W-1:0] mode,
    output dec_t              dec
);

    assign dec = split_addr(addr, mode);

endmodule

// File: rtl/dpg_bank_trk.sv
module dpg_bank_trk
    import dpg_pkg::*;
#(
    parameter int TMO_CYCLES = 1188
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tmo_en,
    input  logic                        act_en,
    input  logic [BK_W-1:0]             act_bank,
    input  logic [CA_W-1:0]             act_row,
    input  logic                        pre_en,
    input  logic [BK_W-1:0]             pre_bank,
    output logic [BANK_N-1:0]           open_q,
    output logic [BANK_N-1:0][CA_W-1:0] row_q,
    output logic [BANK_N-1:0]           expired
);

    localparam int CNT_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYCLES);

    for (genvar g = 0; g < BANK_N; g++) begin : g_bank
        logic             open_r;
        logic [CA_W-1:0]  row_r;
        logic [CNT_W-1:0] age_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                row_r  <= '0;
                age_r  <= '0;
            end else if (act_en && act_bank == BK_W'(g)) begin
                open_r <= 1'b1;
                row_r  <= act_row;
                age_r  <= '0;
            end else if (pre_en && pre_bank == BK_W'(g)) begin
                open_r <= 1'b0;
                age_r  <= '0;
            end else if (open_r && tmo_en && age_r != LIMIT) begin
                age_r  <= age_r + 1'b1;
            end
        end

        assign open_q[g]  = open_r;
        assign row_q[g]   = row_r;
        assign expired[g] = open_r && tmo_en && (age_r == LIMIT);
    end

endmodule

// File: rtl/dpg_seq.sv
module dpg_seq
    import dpg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  dec_t                        req_dec,
    input  logic                        ref_req,
    input  logic [BANK_N-1:0]           open_q,
    input  logic [BANK_N-1:0][CA_W-1:0] row_q,
    input  logic [BANK_N-1:0]           expired,
    output logic                        req_ready,
    output logic                        ref_ack,
    output op_e                         cmd_op,
    output logic [BK_W-1:0]             cmd_bank,
    output logic [CA_W-1:0]             cmd_addr,
    output logic                        act_en,
    output logic [BK_W-1:0]             act_bank,
    output logic [CA_W-1:0]             act_row,
    output logic                        pre_en,
    output logic [BK_W-1:0]             pre_bank
);

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_ACT, S_COL, S_RPRE, S_RACK, S_TPRE
    } st_e;

    st_e  state;
    dec_t cur;
    logic hit;

    assign hit = open_q[req_dec.bank] && (row_q[req_dec.bank] == req_dec.row);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (ref_req) begin
                        state <= (|open_q) ? S_RPRE : S_RACK;
                    end else if (|expired) begin
                        state <= S_TPRE;
                    end else if (req_valid) begin
                        cur <= req_dec;
                        if (hit)                       state <= S_COL;
                        else if (open_q[req_dec.bank]) state <= S_PRE;
                        else                           state <= S_ACT;
                    end
                end
                S_PRE:  state <= S_ACT;
                S_ACT:  state <= S_COL;
                S_COL:  state <= S_IDLE;
                S_RPRE: state <= ($countones(open_q) > 1) ? S_RPRE : S_RACK;
                S_RACK: state <= S_IDLE;
                S_TPRE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_op   = OP_NOP;
        cmd_bank = cur.bank;
        cmd_addr = '0;
        case (state)
            S_PRE:  cmd_op = OP_PRE;
            S_ACT: begin
                cmd_op   = OP_ACT;
                cmd_addr = cur.row;
            end
            S_COL: begin
                cmd_op   = OP_COL;
                cmd_addr = cur.col;
            end
            S_RPRE: begin
                cmd_op   = OP_PRE;
                cmd_bank = lowest_set(open_q);
            end
            S_TPRE: begin
                cmd_op   = OP_PRE;
                cmd_bank = lowest_set(expired);
            end
            default: ;
        endcase
    end

    assign act_en    = (state == S_ACT);
    assign act_bank  = cur.bank;
    assign act_row   = cur.row;
    assign pre_en    = (cmd_op == OP_PRE);
    assign pre_bank  = cmd_bank;
    assign req_ready = (state == S_IDLE) && !ref_req && (expired == '0);
    assign ref_ack   = (state == S_RACK);

endmodule

// File: rtl/dram_page_ctl.sv
module dram_page_ctl
    import dpg_pkg::*;
#(
    parameter int TMO_CYCLES = 1188
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_tmo_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic [1:0]        cmd_op,
    output logic [1:0]        cmd_bank,
    output logic [10:0]       cmd_addr
);

    dec_t                        req_dec;
    logic [BANK_N-1:0]           open_q;
    logic [BANK_N-1:0][CA_W-1:0] row_q;
    logic [BANK_N-1:0]           expired;
    logic                        act_en;
    logic [BK_W-1:0]             act_bank;
    logic [CA_W-1:0]             act_row;
    logic                        pre_en;
    logic [BK_W-1:0]             pre_bank;
    op_e                         op_w;

    dpg_addr_dec u_dec (
        .addr (req_addr),
        .mode (cfg_mode),
        .dec  (req_dec)
    );

    dpg_bank_trk #(.TMO_CYCLES(TMO_CYCLES)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .tmo_en   (cfg_tmo_en),
        .act_en   (act_en),
        .act_bank (act_bank),
        .act_row  (act_row),
        .pre_en   (pre_en),
        .pre_bank (pre_bank),
        .open_q   (open_q),
        .row_q    (row_q),
        .expired  (expired)
    );

    dpg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_dec   (req_dec),
        .ref_req   (ref_req),
        .open_q    (open_q),
        .row_q     (row_q),
        .expired   (expired),
        .req_ready (req_ready),
        .ref_ack   (ref_ack),
        .cmd_op    (op_w),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .act_en    (act_en),
        .act_bank  (act_bank),
        .act_row   (act_row),
        .pre_en    (pre_en),
        .pre_bank  (pre_bank)
    );

    assign cmd_op = op_w;

endmodule

// File: rtl/dpg_ctl_chk.sv
module dpg_ctl_chk #(
    parameter int TMO_CYCLES = 1188
) (
    input logic       clk,
    input logic       rst,
    input logic       cfg_tmo_en,
    input logic       req_ready,
    input logic       ref_req,
    input logic       ref_ack,
    input logic [1:0] cmd_op,
    input logic [1:0] cmd_bank,
    input logic [3:0] open_q
);

    p_act_closed_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 2'd1 |-> !open_q[cmd_bank]);

    p_col_open_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 2'd2 |-> open_q[cmd_bank]);

    p_pre_open_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 2'd3 |-> open_q[cmd_bank]);

    p_act_col_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 2'd1 |=> cmd_op == 2'd2);

    p_ack_closed_r7: assert property (@(posedge clk) disable iff (rst)
        ref_ack |-> open_q == 4'd0);

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        ref_ack |=> !ref_ack);

    p_ready_ref_r7: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> !req_ready);

    for (genvar g = 0; g < 4; g++) begin : g_age
        int unsigned held;
        always_ff @(posedge clk) begin
            if (rst)                       held <= 0;
            else if (open_q[g] && cfg_tmo_en) held <= held + 1;
            else                           held <= 0;
        end
        p_ras_bound_r9: assert property (@(posedge clk) disable iff (rst)
            held <= TMO_CYCLES + 8);
    end

endmodule

bind dram_page_ctl dpg_ctl_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_tmo_en (cfg_tmo_en),
    .req_ready  (req_ready),
    .ref_req    (ref_req),
    .ref_ack    (ref_ack),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .open_q     (open_q)
);

// File: tb/dram_page_ctl_bench.sv
module dram_page_ctl_bench;

    localparam int TB_TMO = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_mode = 3'd4;
    logic        cfg_tmo_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        ref_req = 1'b0;
    logic        ref_ack;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [10:0] cmd_addr;

    always #4 clk = ~clk;

    dram_page_ctl #(.TMO_CYCLES(TB_TMO)) u_dram_page_ctl (
        .clk        (clk),
        .rst        (rst),
        .cfg_mode   (cfg_mode),
        .cfg_tmo_en (cfg_tmo_en),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .ref_req    (ref_req),
        .ref_ack    (ref_ack),
        .cmd_op     (cmd_op),
        .cmd_bank   (cmd_bank),
        .cmd_addr   (cmd_addr)
    );

    typedef struct {
        int    op;
        int    bank;
        int    addr;
        string tag;
        bit    timed;
    } exp_t;

    exp_t  expq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    act_cyc[4];
    bit    m_open[4];
    int    m_row[4];
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: compare every issued command against the scoreboard
    always @(negedge clk) begin
        if (!rst && cmd_op != 2'd0) begin
            if (cmd_op == 2'd1) act_cyc[cmd_bank] = cyc;
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected command op", int'(cmd_op), 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(int'(cmd_op) == e.op, {e.tag, " op"}, int'(cmd_op), e.op);
                check(int'(cmd_bank) == e.bank, {e.tag, " bank"}, int'(cmd_bank), e.bank);
                if (e.op != 3)
                    check(int'(cmd_addr) == e.addr, {e.tag, " R6 addr"}, int'(cmd_addr), e.addr);
                if (e.timed)
                    check(cyc - act_cyc[cmd_bank] == TB_TMO + 2, "R9 precharge cycle",
                          cyc - act_cyc[cmd_bank], TB_TMO + 2);
            end
        end
    end

    function automatic int cwid(input int m);
        return (m < 3) ? 9 : (m < 6) ? 10 : 11;
    endfunction

    function automatic int bwid(input int m);
        if (m == 2 || m == 5) return 2;
        if (m == 1 || m == 4 || m == 7) return 1;
        return 0;
    endfunction

    function automatic int mk_addr(input int m, input int row, input int bank, input int col);
        return col * 2 + bank * (2 << cwid(m)) + row * (2 << (cwid(m) + bwid(m)));
    endfunction

    task automatic push(input int op, input int bank, input int addr, input string tag, input bit timed);
        exp_t e;
        e.op = op; e.bank = bank; e.addr = addr; e.tag = tag; e.timed = timed;
        expq.push_back(e);
    endtask

    task automatic drain();
        while (expq.size() != 0) @(posedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_req(input int a, input string tag);
        int m;
        int cw;
        int bb;
        int col;
        int bank;
        int row;
        m    = int'(cfg_mode);
        cw   = cwid(m);
        bb   = bwid(m);
        col  = (a / 2) % (1 << cw);
        bank = (a / (2 << cw)) % (1 << bb);
        row  = (a / (2 << (cw + bb))) % (1 << cw);
        if (m_open[bank] && m_row[bank] == row) begin
            push(2, bank, col, tag, 1'b0);
        end else begin
            if (m_open[bank]) push(3, bank, 0, tag, 1'b0);
            push(1, bank, row, tag, 1'b0);
            push(2, bank, col, tag, 1'b0);
        end
        m_open[bank] = 1'b1;
        m_row[bank]  = row;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 24'(a);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
    endtask

    task automatic do_refresh();
        int n;
        for (int b = 0; b < 4; b++) begin
            if (m_open[b]) push(3, b, 0, "R7 refresh precharge", 1'b0);
            m_open[b] = 1'b0;
        end
        @(negedge clk);
        ref_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check(!req_ready, "R7 ready low during refresh", int'(req_ready), 0);
        end while (!ref_ack && n < 50);
        check(ref_ack, "R7 acknowledge", int'(ref_ack), 1);
        check(expq.size() == 0, "R7 precharges before ack", expq.size(), 0);
        ref_req = 1'b0;
        @(negedge clk);
        check(!ref_ack, "R7 ack one cycle", int'(ref_ack), 0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) begin
            m_open[b] = 1'b0;
            m_row[b]  = 0;
            act_cyc[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready, "R11 ready after reset", int'(req_ready), 1);
        check(cmd_op == 2'd0, "R11 no command after reset", int'(cmd_op), 0);
        check(!ref_ack, "R11 ack low after reset", int'(ref_ack), 0);

        // 1M-word two-way: bank bit 11, column 10..1, row 21..12
        cfg_mode = 3'd4;
        do_req(mk_addr(4, 5, 0, 3), "R5 R11 closed bank");
        do_req(mk_addr(4, 5, 0, 9), "R3 page hit");
        do_req(mk_addr(4, 5, 0, 9) + 2048, "R1 next page other bank");
        do_req(mk_addr(4, 7, 0, 1), "R4 miss on open bank");
        do_req(mk_addr(4, 7, 0, 100) + 1 + (3 << 22), "R2 ignored bits hit");
        do_refresh();
        do_req(mk_addr(4, 7, 0, 4), "R8 after refresh");
        do_req(mk_addr(4, 5, 1, 4), "R8 second bank after refresh");
        do_refresh();

        cfg_mode = 3'd5;
        do_req(mk_addr(5, 300, 2, 17), "R1 four-way bank 2");
        do_req(mk_addr(5, 301, 3, 18), "R1 four-way bank 3");
        do_req(mk_addr(5, 300, 2, 19), "R1 R3 four-way hit");
        do_refresh();

        cfg_mode = 3'd7;
        do_req(mk_addr(7, 2047, 1, 2047), "R1 4M two-way top row");
        do_req(mk_addr(7, 3, 0, 5), "R1 4M two-way bank 0");
        do_refresh();

        cfg_mode = 3'd0;
        do_req(mk_addr(0, 9, 0, 511), "R1 page-only");
        do_req(mk_addr(0, 9, 0, 511) + 1024, "R1 page-only next page misses");
        do_refresh();

        cfg_mode = 3'd2;
        do_req(mk_addr(2, 6, 1, 7), "R1 256K four-way");
        do_req(mk_addr(2, 6, 3, 7), "R1 256K four-way bank 3");
        do_refresh();

        // watchdog off: row stays open across a long idle gap
        cfg_mode = 3'd4;
        do_req(mk_addr(4, 12, 1, 6), "R10 open");
        repeat (3 * TB_TMO) @(negedge clk);
        check(expq.size() == 0, "R10 no stray commands", expq.size(), 0);
        do_req(mk_addr(4, 12, 1, 8), "R10 still a hit");
        do_refresh();

        // watchdog on
        cfg_tmo_en = 1'b1;
        do_req(mk_addr(4, 20, 1, 2), "R9 open for timeout");
        push(3, 1, 0, "R9 timeout precharge", 1'b1);
        m_open[1] = 1'b0;
        repeat (TB_TMO + 10) @(negedge clk);
        check(expq.size() == 0, "R9 precharge issued", expq.size(), 0);
        do_req(mk_addr(4, 20, 1, 3), "R9 reopen after timeout");
        do_refresh();
        cfg_tmo_en = 1'b0;

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R3 scoreboard empty", expq.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule